// File: doc/BRIEF.md
# Retired Instruction Halfword Counter

This block keeps the running size of retired instructions, measured in halfwords, for a trace encoder that works either in branch-message mode or in branch-history mode. Each cycle it looks at one retirement: a valid flag, a flag that marks a 32-bit instruction, and a flag that marks an instruction cut short by an exception or interrupt. A compressed (16-bit) instruction adds one halfword and a full-size instruction adds two. Branches are counted the same way.

The count is cleared when tracing starts or restarts, and again whenever the message builder reports that it has carried the count in a message. When the count reaches its largest value, the block holds it there and raises an overflow event. The event has one of two forms. The resource-full form uses code 0 and is legal in both modes. The synchronizing form uses code 4 and is only legal in branch mode, where a configuration bit chooses it. Halfwords that retire while the event waits are kept aside. Once the event is carried out, counting resumes from those halfwords. Building and serializing the messages is done elsewhere.

Top module: `hw_retire_counter`

## Requirements
- R1: After reset the count is 0, no overflow event is pending, and the event code output is 0.
- R2: A valid retirement that is not aborted adds 1 to the count when `ret_wide` is 0 (16-bit) and 2 when `ret_wide` is 1 (32-bit). The new count shows one cycle later.
- R3: A retirement flagged by `ret_abort`, or a cycle with `ret_valid` low, leaves the count unchanged.
- R4: `trace_start` clears the count, drops any pending event and discards any kept-aside halfwords. An increment in the same cycle is added to zero.
- R5: `cnt_sent` with no event pending clears the count to 0. An increment in the same cycle is added to zero.
- R6: When the count plus the increment reaches or passes MAX (all ones in `CNT_W` bits), the count becomes MAX, `cnt_full` and `ovf_pend` go high on the next cycle, and any part of the increment beyond MAX is kept aside.
- R7: In history mode (`mode_hist` = 1), an overflow is always raised as resource-full: `ovf_is_sync` = 0 and `ovf_code` = 0.
- R8: In branch mode (`mode_hist` = 0), an overflow is raised as synchronizing (`ovf_is_sync` = 1, `ovf_code` = 4) when `sync_sel` = 1, and as resource-full (`ovf_code` = 0) otherwise. While no event is pending, `ovf_code` is 0.
- R9: The form of an event is fixed when the event is raised. Later changes to `mode_hist` or `sync_sel` do not change it while it is pending.
- R10: While an event is pending, the count stays at MAX, and retired halfwords add to the kept-aside amount, which saturates at MAX.
- R11: `cnt_sent` while an event is pending clears the event. The count restarts from the kept-aside amount plus the increment of that cycle, and a new event is raised if that total reaches MAX.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ret_valid | input | 1 | An instruction retires this cycle |
| ret_wide | input | 1 | 1: 32-bit instruction, 0: 16-bit instruction |
| ret_abort | input | 1 | Instruction raised an exception or was interrupted |
| trace_start | input | 1 | Tracing starts or restarts |
| cnt_sent | input | 1 | The count was carried in an emitted message |
| mode_hist | input | 1 | 1: history mode, 0: branch mode |
| sync_sel | input | 1 | Branch mode only: report overflow as synchronizing |
| hw_count | output | CNT_W | Current halfword count |
| cnt_full | output | 1 | Count is at MAX |
| ovf_pend | output | 1 | Overflow event waiting to be sent |
| ovf_is_sync | output | 1 | Pending event is synchronizing (1) or resource-full (0) |
| ovf_code | output | 3 | Event code: 4 for synchronizing, 0 otherwise |

## Verification
Directed sequences first step single retirements of each size, aborted and idle cycles, and clears that land together with an increment. Together they separate the add-one, add-two, no-change and add-on-zero cases. Further directed runs fill the counter so that it lands exactly on MAX in one run and passes it by one halfword in another. These runs show whether the excess is kept aside and whether counting restarts from it after the send. They also change the mode inputs while an event is pending, which shows whether the event form was fixed when the event was raised. A long seeded random run then mixes every input with send strobes that come more often while an event is pending. An independent model checks each cycle, which covers long waits with saturation of the kept-aside amount and restarts that raise a new event at once.

// File: rtl/hwc_pkg.sv
package hwc_pkg;
    typedef enum logic {
        OVF_RFULL = 1'b0,
        OVF_SYNC  = 1'b1
    } ovf_kind_e;

    localparam int          CODE_W     = 3;
    localparam logic [2:0]  RFULL_CODE = 3'd0;
    localparam logic [2:0]  SYNC_CODE  = 3'd4;
    localparam int          STEP_W     = 2;
endpackage

// File: rtl/hwc_step_decode.sv
module hwc_step_decode
    import hwc_pkg::*;
(
    input  logic              ret_valid,
    input  logic              ret_wide,
    input  logic              ret_abort,
    output logic [STEP_W-1:0] step
);
    always_comb begin
        if (ret_valid && !ret_abort) begin
            step = ret_wide ? STEP_W'(2) : STEP_W'(1);
        end else begin
            step = '0;
        end
    end
endmodule

// File: rtl/hwc_sat_add.sv
module hwc_sat_add
    import hwc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]      base,
    input  logic [STEP_W-1:0] step,
    output logic [W-1:0]      total,
    output logic              hit,
    output logic [W-1:0]      excess
);
    localparam logic [W:0] LIMIT = {1'b0, {W{1'b1}}};

    logic [W:0] sum_ext;
    logic [W:0] over_ext;

    always_comb begin
        sum_ext  = {1'b0, base} + (W + 1)'(step);
        hit      = (sum_ext >= LIMIT);
        over_ext = sum_ext - LIMIT;
        total    = hit ? LIMIT[W-1:0] : sum_ext[W-1:0];
        excess   = hit ? over_ext[W-1:0] : '0;
    end
endmodule

// File: rtl/hwc_ovf_policy.sv
module hwc_ovf_policy
    import hwc_pkg::*;
(
    input  logic              mode_hist,
    input  logic              sync_sel,
    input  logic              pend,
    input  ovf_kind_e         kind_held,
    output ovf_kind_e         kind_new,
    output logic [CODE_W-1:0] code
);
    always_comb begin
        if (!mode_hist && sync_sel) begin
            kind_new = OVF_SYNC;
        end else begin
            kind_new = OVF_RFULL;
        end
        if (!pend) begin
            code = RFULL_CODE;
        end else if (kind_held == OVF_SYNC) begin
            code = SYNC_CODE;
        end else begin
            code = RFULL_CODE;
        end
    end
endmodule

// File: rtl/hw_retire_counter.sv
module hw_retire_counter
    import hwc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ret_valid,
    input  logic             ret_wide,
    input  logic             ret_abort,
    input  logic             trace_start,
    input  logic             cnt_sent,
    input  logic             mode_hist,
    input  logic             sync_sel,
    output logic [CNT_W-1:0] hw_count,
    output logic             cnt_full,
    output logic             ovf_pend,
    output logic             ovf_is_sync,
    output logic [2:0]       ovf_code
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] spare;
        logic             pend;
        ovf_kind_e        kind;
    } hwc_state_t;

    hwc_state_t st_d, st_q;

    logic [STEP_W-1:0] step;
    logic [CNT_W-1:0]  main_base;
    logic [CNT_W-1:0]  main_total, main_excess;
    logic              main_hit;
    logic [CNT_W-1:0]  spare_total, spare_excess;
    logic              spare_hit;
    ovf_kind_e         kind_new;
    logic              hold_event;

    hwc_step_decode u_step (
        .ret_valid (ret_valid),
        .ret_wide  (ret_wide),
        .ret_abort (ret_abort),
        .step      (step)
    );

    always_comb begin
        if (trace_start) begin
            main_base = '0;
        end else if (st_q.pend) begin
            main_base = st_q.spare;
        end else if (cnt_sent) begin
            main_base = '0;
        end else begin
            main_base = st_q.count;
        end
    end

    hwc_sat_add #(.W(CNT_W)) u_main_add (
        .base   (main_base),
        .step   (step),
        .total  (main_total),
        .hit    (main_hit),
        .excess (main_excess)
    );

    hwc_sat_add #(.W(CNT_W)) u_spare_add (
        .base   (st_q.spare),
        .step   (step),
        .total  (spare_total),
        .hit    (spare_hit),
        .excess (spare_excess)
    );

    hwc_ovf_policy u_policy (
        .mode_hist (mode_hist),
        .sync_sel  (sync_sel),
        .pend      (st_q.pend),
        .kind_held (st_q.kind),
        .kind_new  (kind_new),
        .code      (ovf_code)
    );

    assign hold_event = st_q.pend && !cnt_sent && !trace_start;

    always_comb begin
        st_d = st_q;
        if (hold_event) begin
            st_d.count = CNT_MAX;
            st_d.spare = spare_total;
        end else begin
            st_d.count = main_total;
            st_d.pend  = main_hit;
            st_d.spare = main_hit ? main_excess : '0;
            if (main_hit) begin
                st_d.kind = kind_new;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{count: '0, spare: '0, pend: 1'b0, kind: OVF_RFULL};
        end else begin
            st_q <= st_d;
        end
    end

    assign hw_count    = st_q.count;
    assign cnt_full    = (st_q.count == CNT_MAX);
    assign ovf_pend    = st_q.pend;
    assign ovf_is_sync = (st_q.kind == OVF_SYNC) && st_q.pend;
endmodule

// File: rtl/hwc_checker.sv
module hwc_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ret_valid,
    input logic             ret_wide,
    input logic             ret_abort,
    input logic             trace_start,
    input logic             cnt_sent,
    input logic             mode_hist,
    input logic             sync_sel,
    input logic [CNT_W-1:0] hw_count,
    input logic             cnt_full,
    input logic             ovf_pend,
    input logic             ovf_is_sync,
    input logic [2:0]       ovf_code
);
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    // R3: an aborted or idle cycle keeps the count
    a_r3_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf_pend && !trace_start && !cnt_sent && (!ret_valid || ret_abort))
        |=> (hw_count == $past(hw_count)));

    // R4: start clears, leaving at most the same-cycle increment
    a_r4_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        trace_start |=> (!ovf_pend && hw_count <= CNT_W'(2)));

    // R6: a pending event means the count is held at its maximum
    a_r6_pend_full: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pend |-> (cnt_full && hw_count == CMAX));

    // R7: history mode never raises the synchronizing form
    a_r7_hist_rfull: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ovf_pend) && $past(mode_hist)) |-> (!ovf_is_sync && ovf_code == 3'd0));

    // R8: code follows the event form
    a_r8_code_map: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_code == (ovf_is_sync ? 3'd4 : 3'd0));

    // R9: form stays fixed while the event waits
    a_r9_kind_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_pend && !trace_start && !cnt_sent) |=> $stable(ovf_is_sync));

    // R10: the event stays until sent or restarted
    a_r10_event_held: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_pend && !trace_start && !cnt_sent) |=> ovf_pend);

    // R2: growth per cycle is at most two halfwords
    a_r2_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf_pend && !trace_start && !cnt_sent)
        |=> (ovf_pend || (hw_count >= $past(hw_count)
                          && hw_count - $past(hw_count) <= CNT_W'(2))));
endmodule

bind hw_retire_counter hwc_checker #(.CNT_W(CNT_W)) u_hwc_checker (.*);

// File: tb/sim_hw_retire_counter.sv
module sim_hw_retire_counter;
    localparam int CW  = 4;
    localparam int MAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ret_valid = 0, ret_wide = 0, ret_abort = 0;
    logic          trace_start = 0, cnt_sent = 0, mode_hist = 0, sync_sel = 0;
    logic [CW-1:0] hw_count;
    logic          cnt_full, ovf_pend, ovf_is_sync;
    logic [2:0]    ovf_code;

    int n_chk = 0;
    int n_bad = 0;
    int m_cnt = 0, m_pend = 0, m_sync = 0, m_left = 0;
    bit done = 0;

    always #2 clk = ~clk;

    hw_retire_counter #(.CNT_W(CW)) u0 (.*);

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int step_of(input bit v, input bit w, input bit a);
        return (v && !a) ? (w ? 2 : 1) : 0;
    endfunction

    task automatic model(input bit v, input bit w, input bit a, input bit ts,
                         input bit sent, input bit mh, input bit ss);
        int s = step_of(v, w, a);
        int sum;
        if (m_pend != 0 && !ts && !sent) begin
            m_left = (m_left + s > MAX) ? MAX : m_left + s;
            return;
        end
        if (ts) sum = s;
        else if (m_pend != 0) sum = m_left + s;
        else if (sent) sum = s;
        else sum = m_cnt + s;
        if (sum >= MAX) begin
            m_cnt = MAX; m_pend = 1; m_left = sum - MAX;
            m_sync = (!mh && ss) ? 1 : 0;
        end else begin
            m_cnt = sum; m_pend = 0; m_left = 0;
        end
    endtask

    task automatic compare_all();
        chk("R2/R3 count", int'(hw_count), m_cnt);
        chk("R6 full", int'(cnt_full), (m_cnt == MAX) ? 1 : 0);
        chk("R6/R10 pend", int'(ovf_pend), m_pend);
        chk("R8 sync", int'(ovf_is_sync), m_pend ? m_sync : 0);
        chk("R7/R8 code", int'(ovf_code), (m_pend && m_sync) ? 4 : 0);
    endtask

    task automatic cyc(input bit v, input bit w, input bit a, input bit ts,
                       input bit sent, input bit mh, input bit ss);
        @(negedge clk);
        ret_valid = v; ret_wide = w; ret_abort = a;
        trace_start = ts; cnt_sent = sent; mode_hist = mh; sync_sel = ss;
        model(v, w, a, ts, sent, mh, ss);
        @(posedge clk);
        #1;
        compare_all();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        int seed = 32'h5EED_0123;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 count", int'(hw_count), 0);
        chk("R1 pend", int'(ovf_pend), 0);
        chk("R1 code", int'(ovf_code), 0);

        cyc(1,0,0,0,0,0,0); chk("R2 narrow", int'(hw_count), 1);
        cyc(1,1,0,0,0,0,0); chk("R2 wide", int'(hw_count), 3);
        cyc(1,1,1,0,0,0,0); chk("R3 abort", int'(hw_count), 3);
        cyc(0,1,0,0,0,0,0); chk("R3 idle", int'(hw_count), 3);
        cyc(1,1,0,0,1,0,0); chk("R5 sent+inc", int'(hw_count), 2);
        cyc(1,0,0,1,0,0,0); chk("R4 start+inc", int'(hw_count), 1);
        // land exactly on MAX in branch mode, synchronizing form
        for (int i = 0; i < 7; i++) cyc(1,1,0,0,0,0,1);
        chk("R6 exact", int'(ovf_pend), 1);
        chk("R8 sync code", int'(ovf_code), 4);
        cyc(1,1,0,0,0,1,0); chk("R9 kind kept", int'(ovf_is_sync), 1);
        cyc(1,1,0,0,0,1,0); chk("R10 held", int'(hw_count), MAX);
        cyc(1,0,0,0,1,1,0); chk("R11 restart", int'(hw_count), 5);
        chk("R11 cleared", int'(ovf_pend), 0);
        // history mode overflow
        for (int i = 0; i < 5; i++) cyc(1,1,0,0,0,1,1);
        chk("R7 hist pend", int'(ovf_pend), 1);
        chk("R7 hist code", int'(ovf_is_sync), 0);
        cyc(0,0,0,1,0,1,1); chk("R4 start drops", int'(ovf_pend), 0);
        chk("R4 start count", int'(hw_count), 0);
        // pass MAX by one, branch mode resource-full
        for (int i = 0; i < 7; i++) cyc(1,1,0,0,0,0,0);
        cyc(1,1,0,0,0,0,0); chk("R6 pass", int'(hw_count), MAX);
        chk("R8 rfull", int'(ovf_code), 0);
        cyc(0,0,0,0,1,0,0); chk("R11 leftover", int'(hw_count), 1);
        // long wait: saturate leftover, then restart re-raises
        for (int i = 0; i < 7; i++) cyc(1,1,0,0,0,0,0);
        for (int i = 0; i < 10; i++) cyc(1,1,0,0,0,0,0);
        cyc(1,0,0,0,1,0,0); chk("R10 sat re-raise", int'(ovf_pend), 1);

        for (int i = 0; i < 4000; i++) begin
            bit v  = ($urandom % 10) < 7;
            bit w  = $urandom % 2;
            bit a  = ($urandom % 10) == 0;
            bit ts = ($urandom % 50) == 0;
            bit sn = m_pend ? (($urandom % 10) < 3) : (($urandom % 30) == 0);
            bit mh = (i / 500) % 2;
            bit ss = ($urandom % 4) != 0;
            cyc(v, w, a, ts, sn, mh, ss);
        end
        finish_run();
    end
endmodule